// File: doc/BRIEF.md
# Host Memory Wait-State Bridge

This block connects an asynchronous 8-bit host bus to an internal single-beat memory port clocked by a much faster on-chip clock. It watches host memory cycles. When the host addresses a configured memory window, the block raises an active-high stall request. An external pull-down stage turns that request into the host's active-low WAIT line. The stall stays up while a programmable delay counter runs and the internal transfer completes.

The request is raised as soon as the memory strobe is seen low with a settled in-window address. It does not wait for the read or write strobe, because that would leave too little setup time before the host samples WAIT. The address is accepted only after it has stayed inside the window for several consecutive internal clocks, so that short transients on the bus start no transfer.

Read data returned by the internal port is held in a buffer. It is driven towards the host once the stall has been released and while the host read strobe is still low. A small configuration register, written through a host I/O port, sets the delay and switches stall insertion on or off.

Top module: `zwait_bridge`

## Requirements
- R1: While reset is applied and after it is released with an idle host bus, `wait_req`, `mem_req` and `host_dout_oe` are low.
- R2: With insertion enabled, and with the memory strobe and a window address applied together at the pins, `wait_req` is first high exactly 6 clocks later: 2 synchroniser stages, 3 stability stages and 1 registered trigger. This happens whether or not RD or WR is already low.
- R3: An address counts as inside the window only after 3 consecutive synchronised clocks inside it. An excursion into the window lasting 2 clocks starts no transfer. One lasting 3 clocks starts one.
- R4: Host memory cycles outside the inclusive window `WIN_LO`..`WIN_HI` (default 0x8000..0xBFFF) never raise `wait_req` and never raise `mem_req`.
- R5: Both reads and writes that hit the window are stalled. A write passes the host data byte to `mem_wdata` with `mem_we` high.
- R6: A host I/O write (IORQ and WR low) to the port whose low address byte equals `CFG_PORT` (default 0x3C) loads the configuration byte. Bit 0 enables stalling, and bits 7:1 give the delay count N. The reset value is 0x01. I/O writes to any other port leave the configuration unchanged.
- R7: With insertion enabled, `wait_req` stays high until the delay counter, loaded with N at the trigger, reaches zero and the memory port has acknowledged. With an acknowledge arriving one clock after the request, the high time is max(4, N+1) clocks.
- R8: The read byte captured at the acknowledge is presented on `host_dout`, with `host_dout_oe` high, only after `wait_req` has fallen and only while RD is low.
- R9: Each period of the memory strobe being low causes exactly one memory transfer. The block re-arms only after the strobe returns high, so back-to-back cycles each get one transfer.
- R10: With bit 0 of the configuration clear, window accesses still perform the memory transfer and return read data, but `wait_req` stays low.
- R11: `mem_addr` carries the host address minus `WIN_LO`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mreq_n | input | 1 | Host memory request strobe, active low, asynchronous |
| host_iorq_n | input | 1 | Host I/O request strobe, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_addr | input | ADDR_W | Host address bus |
| host_din | input | DATA_W | Data driven by the host |
| host_dout | output | DATA_W | Buffered read data towards the host |
| host_dout_oe | output | 1 | Enable for the host data bus driver |
| wait_req | output | 1 | Active-high stall request to the external pull-down |
| mem_req | output | 1 | Internal transfer request, held until acknowledged |
| mem_we | output | 1 | High for a write transfer |
| mem_addr | output | ADDR_W | Window-relative transfer address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data from the internal port |
| mem_ack | input | 1 | One-clock acknowledge of the transfer |

## Verification
A control state stuck outside idle shows at the ports as a stall that never falls, or as a second access that never raises `wait_req` or `mem_req`. Both are visible within one host cycle. A stability filter that is too short or too long moves the first rise of `wait_req` off its sixth clock, and it lets a two-clock address excursion create a transfer. A wrong counter load or a wrong release condition changes the measured stall length against max(4, N+1) in the same access. A missing re-arm guard shows as an extra transfer count while the strobe is held low.

// File: rtl/zwb_pkg.sv
package zwb_pkg;

  // Access sequencer states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // waiting for an in-window memory strobe
    ST_ARM   = 3'd1,  // stall raised, waiting for RD or WR
    ST_ISSUE = 3'd2,  // internal request outstanding
    ST_HOLD  = 3'd3,  // acknowledged, delay counter still running
    ST_DONE  = 3'd4   // released, waiting for the strobe to rise
  } zwb_state_e;

endpackage

// File: rtl/zwb_sync.sv
module zwb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/zwb_window.sv
module zwb_window #(
  parameter int          ADDR_W   = 16,
  parameter int          STABLE_N = 3,
  parameter int unsigned WIN_LO   = 32'h8000,
  parameter int unsigned WIN_HI   = 32'hBFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              win_ok
);

  localparam logic [ADDR_W-1:0] LO = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(WIN_HI);

  logic                in_raw;
  logic [STABLE_N-1:0] hist_q;
  logic [STABLE_N-1:0] hist_n;

  // Window compare; a zero lower bound needs no comparator
  generate
    if (WIN_LO == 0) begin : g_top_only
      assign in_raw = (addr <= HI);
    end else begin : g_both
      assign in_raw = (addr >= LO) && (addr <= HI);
    end
  endgenerate

  // Stability history: oldest sample in the top bit
  generate
    if (STABLE_N == 1) begin : g_one
      assign hist_n = in_raw;
    end else begin : g_many
      assign hist_n = {hist_q[STABLE_N-2:0], in_raw};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_n;
  end

  assign win_ok = &hist_q;

  // R3: a single outside sample blocks the next cycle
  p_gap_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_raw |=> !win_ok);

  // R3: acceptance requires the previous sample inside
  p_needs_history_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_ok |-> $past(in_raw));

endmodule

// File: rtl/zwb_cfg.sv
module zwb_cfg #(
  parameter int           DATA_W   = 8,
  parameter int           PORT_W   = 8,
  parameter logic [7:0]   CFG_PORT = 8'h3C,
  parameter logic [DATA_W-1:0] CFG_RST = DATA_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iorq_n,
  input  logic              wr_n,
  input  logic [PORT_W-1:0] port,
  input  logic [DATA_W-1:0] din,
  output logic              cfg_en,
  output logic [DATA_W-2:0] cfg_cnt
);

  logic              hit;
  logic [DATA_W-1:0] cfg_q;

  assign hit = !iorq_n && !wr_n && (port == PORT_W'(CFG_PORT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cfg_q <= CFG_RST;
    else if (hit) cfg_q <= din;
  end

  assign cfg_en  = cfg_q[0];
  assign cfg_cnt = cfg_q[DATA_W-1:1];

  // R6: the register changes only through a matching port write
  p_cfg_only_on_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(hit));

endmodule

// File: rtl/zwb_ctrl.sv
module zwb_ctrl
  import zwb_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter int          DATA_W = 8,
  parameter int unsigned WIN_LO = 32'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              win_ok,
  input  logic              cfg_en,
  input  logic [DATA_W-2:0] cfg_cnt,
  output logic              wait_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_dout_oe
);

  localparam int                CW = DATA_W - 1;
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(WIN_LO);

  zwb_state_e        st_q,    st_n;
  logic [CW-1:0]     cnt_q,   cnt_n;
  logic              wait_q,  wait_n;
  logic              acked_q, acked_n;
  logic              isrd_q,  isrd_n;
  logic [ADDR_W-1:0] addr_q,  addr_n;
  logic [DATA_W-1:0] wdat_q,  wdat_n;
  logic [DATA_W-1:0] rbuf_q,  rbuf_n;
  logic              cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // Next-state logic
  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    wait_n  = wait_q;
    acked_n = acked_q;
    isrd_n  = isrd_q;
    addr_n  = addr_q;
    wdat_n  = wdat_q;
    rbuf_n  = rbuf_q;
    if (st_q != ST_IDLE && !cnt_zero) cnt_n = cnt_q - CW'(1);
    unique case (st_q)
      ST_IDLE: begin
        if (!mreq_n && win_ok) begin
          st_n    = ST_ARM;
          cnt_n   = cfg_en ? cfg_cnt : '0;
          wait_n  = cfg_en;
          acked_n = 1'b0;
          addr_n  = addr - LO;
        end
      end
      ST_ARM: begin
        if (mreq_n) begin
          st_n   = ST_IDLE;
          wait_n = 1'b0;
        end else if (!rd_n) begin
          st_n   = ST_ISSUE;
          isrd_n = 1'b1;
        end else if (!wr_n) begin
          st_n   = ST_ISSUE;
          isrd_n = 1'b0;
          wdat_n = din;
        end
      end
      ST_ISSUE: begin
        if (mem_ack) begin
          st_n    = ST_HOLD;
          acked_n = 1'b1;
          if (isrd_q) rbuf_n = mem_rdata;
        end
      end
      ST_HOLD: begin
        if (cnt_zero) begin
          st_n   = ST_DONE;
          wait_n = 1'b0;
        end
      end
      ST_DONE: begin
        if (mreq_n) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      wait_q  <= 1'b0;
      acked_q <= 1'b0;
      isrd_q  <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rbuf_q  <= '0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      wait_q  <= wait_n;
      acked_q <= acked_n;
      isrd_q  <= isrd_n;
      addr_q  <= addr_n;
      wdat_q  <= wdat_n;
      rbuf_q  <= rbuf_n;
    end
  end

  assign wait_req     = wait_q;
  assign mem_req      = (st_q == ST_ISSUE);
  assign mem_we       = !isrd_q;
  assign mem_addr     = addr_q;
  assign mem_wdata    = wdat_q;
  assign host_dout    = rbuf_q;
  assign host_dout_oe = (st_q == ST_DONE) && isrd_q && !rd_n;

  // R7: release only with an expired counter after acknowledge,
  // or when the host abandons the cycle
  p_release_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_q) |-> $past(mreq_n) || ($past(cnt_zero) && $past(acked_q)));

  // R9: one request per acknowledge
  p_single_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);

  // R9: no new trigger while the host strobe stays low after release
  p_no_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_DONE && !mreq_n |=> st_q == ST_DONE);

endmodule

// File: rtl/zwait_bridge.sv
module zwait_bridge #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int unsigned WIN_LO   = 32'h8000,
  parameter int unsigned WIN_HI   = 32'hBFFF,
  parameter logic [7:0]  CFG_PORT = 8'h3C,
  parameter logic [7:0]  CFG_RST  = 8'h01,
  parameter int          SYNC_N   = 2,
  parameter int          STABLE_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mreq_n,
  input  logic              host_iorq_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_dout_oe,
  output logic              wait_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int PORT_W = 8;

  logic [1:0]        rst_pipe_q;
  logic              rst_ni;
  logic [3:0]        strb_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic              mreq_s, iorq_s, rd_s, wr_s;
  logic              win_ok;
  logic              cfg_en;
  logic [DATA_W-2:0] cfg_cnt;

  // Reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  zwb_sync #(.W(4), .STAGES(SYNC_N), .RST_VAL(4'hF)) u_sync_strb (
    .clk(clk), .rst_n(rst_ni),
    .d({host_mreq_n, host_iorq_n, host_rd_n, host_wr_n}),
    .q(strb_s)
  );
  assign {mreq_s, iorq_s, rd_s, wr_s} = strb_s;

  zwb_sync #(.W(ADDR_W), .STAGES(SYNC_N), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst_n(rst_ni), .d(host_addr), .q(addr_s)
  );

  zwb_sync #(.W(DATA_W), .STAGES(SYNC_N), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_ni), .d(host_din), .q(din_s)
  );

  zwb_window #(
    .ADDR_W(ADDR_W), .STABLE_N(STABLE_N), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_window (
    .clk(clk), .rst_n(rst_ni), .addr(addr_s), .win_ok(win_ok)
  );

  zwb_cfg #(
    .DATA_W(DATA_W), .PORT_W(PORT_W), .CFG_PORT(CFG_PORT),
    .CFG_RST(DATA_W'(CFG_RST))
  ) u_cfg (
    .clk(clk), .rst_n(rst_ni), .iorq_n(iorq_s), .wr_n(wr_s),
    .port(addr_s[PORT_W-1:0]), .din(din_s),
    .cfg_en(cfg_en), .cfg_cnt(cfg_cnt)
  );

  zwb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LO(WIN_LO)) u_ctrl (
    .clk(clk), .rst_n(rst_ni),
    .mreq_n(mreq_s), .rd_n(rd_s), .wr_n(wr_s),
    .addr(addr_s), .din(din_s), .win_ok(win_ok),
    .cfg_en(cfg_en), .cfg_cnt(cfg_cnt),
    .wait_req(wait_req), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .host_dout(host_dout), .host_dout_oe(host_dout_oe)
  );

  // R4: a stall starts only from a settled in-window address with the strobe low
  p_wait_needs_window_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(wait_req) |-> $past(win_ok) && !$past(mreq_s));

  // R10: a stall starts only while insertion is enabled
  p_wait_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(wait_req) |-> $past(cfg_en));

  // R8: data is never driven while the host is still stalled
  p_oe_after_release_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    host_dout_oe |-> !wait_req);

  // R1: quiet outputs right after reset release
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_ni) |-> !wait_req && !mem_req);

endmodule

// File: tb/tb_zwait_bridge.sv
`timescale 1ns/1ps
module tb_zwait_bridge;

  localparam real CLK_P = 4.0;

  logic        clk;
  logic        rst_n;
  logic        h_mreq_n, h_iorq_n, h_rd_n, h_wr_n;
  logic [15:0] h_addr;
  logic [7:0]  h_din;
  logic [7:0]  host_dout;
  logic        host_dout_oe;
  logic        wait_req;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_ack;

  int checks, errors;
  int nreq;
  logic [15:0] last_waddr;
  logic [7:0]  last_wdata;
  int lat, hi, reqd;
  logic       oe_s;
  logic [7:0] dout_s;
  bit finished;

  zwait_bridge dut (
    .clk(clk), .rst_n(rst_n),
    .host_mreq_n(h_mreq_n), .host_iorq_n(h_iorq_n),
    .host_rd_n(h_rd_n), .host_wr_n(h_wr_n),
    .host_addr(h_addr), .host_din(h_din),
    .host_dout(host_dout), .host_dout_oe(host_dout_oe),
    .wait_req(wait_req), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Memory model: acknowledge one clock after a request, data from the address
  assign mem_rdata = mem_addr[7:0] ^ 8'hA5;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack    <= 1'b0;
      nreq       <= 0;
      last_waddr <= '0;
      last_wdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack) begin
        nreq <= nreq + 1;
        if (mem_we) begin
          last_waddr <= mem_addr;
          last_wdata <= mem_wdata;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] port, input logic [7:0] val);
    @(negedge clk);
    h_addr = {8'h00, port}; h_din = val; h_iorq_n = 1'b0; h_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    h_iorq_n = 1'b1; h_wr_n = 1'b1; h_addr = 16'h0100;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_access(input logic [15:0] a, input logic w,
                            input logic [7:0] d, input int cyc);
    int req0;
    @(negedge clk);
    h_addr = a; h_din = d; h_mreq_n = 1'b0;
    if (w) h_wr_n = 1'b0; else h_rd_n = 1'b0;
    lat = 0; hi = 0; req0 = nreq;
    for (int k = 1; k <= cyc; k++) begin
      @(posedge clk); #1;
      if (wait_req) begin
        hi++;
        if (lat == 0) lat = k;
      end
    end
    oe_s = host_dout_oe; dout_s = host_dout; reqd = nreq - req0;
    @(negedge clk);
    h_mreq_n = 1'b1; h_rd_n = 1'b1; h_wr_n = 1'b1; h_addr = 16'h0100;
    repeat (6) @(negedge clk);
  endtask

  // {cfg byte, is_write, address, write data}
  localparam logic [32:0] VEC [8] = '{
    {8'h01, 1'b0, 16'h8000, 8'h00},
    {8'h0B, 1'b0, 16'h8123, 8'h00},
    {8'h29, 1'b1, 16'h9F44, 8'h3C},
    {8'h07, 1'b1, 16'hBFFF, 8'hC3},
    {8'h28, 1'b0, 16'h8A55, 8'h00},
    {8'h01, 1'b0, 16'h7FFF, 8'h00},
    {8'h01, 1'b0, 16'hC000, 8'h00},
    {8'h03, 1'b1, 16'h8000, 8'h5E}
  };

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0;
    h_mreq_n = 1'b1; h_iorq_n = 1'b1; h_rd_n = 1'b1; h_wr_n = 1'b1;
    h_addr = 16'h0100; h_din = 8'h00;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 wait_req in reset", wait_req, 0);
    chk("R1 mem_req in reset", mem_req, 0);
    chk("R1 dout_oe in reset", host_dout_oe, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 wait_req after reset", wait_req, 0);
    chk("R1 mem_req after reset", mem_req, 0);

    // Table-driven accesses
    for (int i = 0; i < 8; i++) begin
      logic [7:0]  c;
      logic        w;
      logic [15:0] a;
      logic [7:0]  d;
      logic        en, inw;
      int n, exp_d;
      {c, w, a, d} = VEC[i];
      en  = c[0];
      n   = int'(c[7:1]);
      inw = (a >= 16'h8000) && (a <= 16'hBFFF);
      exp_d = (en && inw) ? ((n + 1 > 4) ? n + 1 : 4) : 0;
      cfg_write(8'h3C, c);
      run_access(a, w, d, 40 + n);
      // R2 / R4 / R10: first rise of the stall
      chk($sformatf("R2 R4 R10 latency vec%0d", i), lat, (en && inw) ? 6 : 0);
      // R7: stall length
      chk($sformatf("R7 stall length vec%0d", i), hi, exp_d);
      // R9 / R4: one transfer inside the window, none outside
      chk($sformatf("R9 R4 transfer count vec%0d", i), reqd, inw ? 1 : 0);
      if (inw && w) begin
        chk($sformatf("R5 R11 write addr vec%0d", i), last_waddr, a - 16'h8000);
        chk($sformatf("R5 write data vec%0d", i), last_wdata, d);
        chk($sformatf("R8 no drive on write vec%0d", i), oe_s, 0);
      end else if (inw) begin
        chk($sformatf("R8 dout_oe vec%0d", i), oe_s, 1);
        chk($sformatf("R8 dout vec%0d", i), dout_s, a[7:0] ^ 8'hA5);
      end else begin
        chk($sformatf("R4 no drive outside vec%0d", i), oe_s, 0);
      end
    end

    // R6: a write to another port leaves N=5 in place
    cfg_write(8'h3C, 8'h0B);
    cfg_write(8'h3D, 8'h00);
    run_access(16'h8040, 1'b0, 8'h00, 50);
    chk("R6 other port ignored, stall length", hi, 6);

    // R3: two-clock excursion into the window starts nothing
    cfg_write(8'h3C, 8'h01);
    begin
      int req0, seen;
      req0 = nreq; seen = 0;
      @(negedge clk);
      h_addr = 16'h0100; h_mreq_n = 1'b0; h_rd_n = 1'b0;
      repeat (8) @(negedge clk);
      h_addr = 16'h8100;
      repeat (2) @(negedge clk);
      h_addr = 16'h0100;
      for (int k = 0; k < 20; k++) begin
        @(posedge clk); #1;
        if (wait_req) seen = 1;
      end
      chk("R3 two-clock glitch no stall", seen, 0);
      chk("R3 two-clock glitch no transfer", nreq - req0, 0);
      @(negedge clk);
      h_mreq_n = 1'b1; h_rd_n = 1'b1;
      repeat (6) @(negedge clk);

      // R3: three clocks in the window is accepted
      req0 = nreq; seen = 0;
      h_mreq_n = 1'b0; h_rd_n = 1'b0;
      repeat (8) @(negedge clk);
      h_addr = 16'h8100;
      repeat (3) @(negedge clk);
      h_addr = 16'h0100;
      for (int k = 0; k < 20; k++) begin
        @(posedge clk); #1;
        if (wait_req) seen = 1;
      end
      chk("R3 three-clock stay accepted", seen, 1);
      chk("R3 three-clock stay one transfer", nreq - req0, 1);
      @(negedge clk);
      h_mreq_n = 1'b1; h_rd_n = 1'b1;
      repeat (6) @(negedge clk);
    end

    // R9: strobe held low long after release gives one transfer;
    // then a back-to-back cycle with a short gap gives one more
    run_access(16'h8200, 1'b1, 8'h11, 300);
    chk("R9 long hold single transfer", reqd, 1);
    @(negedge clk);
    h_addr = 16'h8201; h_din = 8'h22; h_mreq_n = 1'b0; h_wr_n = 1'b0;
    repeat (20) @(negedge clk);
    h_mreq_n = 1'b1; h_wr_n = 1'b1;
    repeat (3) @(negedge clk);
    begin
      int req0;
      req0 = nreq;
      h_addr = 16'h8202; h_din = 8'h33; h_mreq_n = 1'b0; h_wr_n = 1'b0;
      repeat (20) @(negedge clk);
      chk("R9 back-to-back second transfer", nreq - req0, 1);
      chk("R5 back-to-back write data", last_wdata, 8'h33);
      h_mreq_n = 1'b1; h_wr_n = 1'b1;
      repeat (6) @(negedge clk);
    end

    // R10: disabled read still returns data with no stall
    cfg_write(8'h3C, 8'h10);
    run_access(8'h00 | 16'hA077, 1'b0, 8'h00, 40);
    chk("R10 disabled no stall", hi, 0);
    chk("R10 disabled data returned", dout_s, 8'h77 ^ 8'hA5);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule